// File: doc/BRIEF.md
# Cyclic ADC Conversion Sequencer with Redundant-Digit Correction

This block is the digital half of a 12-bit cyclic analog-to-digital converter that resolves 1.5 bits per step. A single gain-of-two switched-capacitor amplifier is reused for every step. The sequencer alternates it between two phases, A and B. During each phase it reads the two comparators belonging to that phase and turns their result into a three-level digit. Once every digit is in, it folds the redundant digits into a plain binary code.

The clock `clk` runs at twice the conversion-cycle rate. One conversion cycle is a phase-A clock period followed by a phase-B clock period, so each conversion cycle yields two digits, most significant first. A 12-bit result takes 6 conversion cycles, which is 12 clock periods. Because each digit can take three values, a comparator threshold may drift by up to an eighth of the full input range and the result stays within one code of ideal.

Top module: `cadc_seq_core`

## Requirements
- R1: While `rst_n` is low, and after it is released, `phase_a_o`, `phase_b_o` and `done_o` are 0 and `code_o` is 0 until the first conversion ends.
- R2: A `start_i` seen high at a rising edge while idle starts a conversion. In the following clock period `phase_a_o` is high. After that the phases alternate B, A, B, ... for RES_BITS clock periods in total (6 A/B pairs for 12 bits).
- R3: `phase_a_o` and `phase_b_o` are never high together, and both are low while idle.
- R4: The comparator pair for a phase is captured at the rising edge that ends that phase's clock period. Phase A uses `cmp_a_i` and phase B uses `cmp_b_i`. Bit 1 is the upper comparator and bit 0 the lower. The pair {1,1} gives digit +1, {0,1} gives 0 and {0,0} gives -1. The inconsistent pair {1,0} is treated as 0.
- R5: With digits d0 (first) to d11 (last), S = sum of dk * 2^(11-k). The code is (S + 4096) / 2, rounded down and limited to 0..4095. Twelve +1 digits give 4095, twelve -1 digits give 0, and all-mid gives 2048.
- R6: `done_o` is high for exactly one clock period, the one right after the last phase period. `code_o` carries the new result in that same period.
- R7: `code_o` changes only in a clock period where `done_o` is high, and otherwise holds its value.
- R8: A `start_i` pulse during a conversion is ignored: the conversion ends on schedule with its own result, and no further phases or done pulse follow.
- R9: For an input x in [-Vref, +Vref], take comparators at +-Vref/4 that are each offset by up to +-Vref/4 (1/8 of full scale) and a residue step of 2r - d*Vref. The code is then within 1 of floor((x + Vref) * 2048 / Vref), limited to 4095.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, two periods per conversion cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start-conversion request |
| cmp_a_i | input | 2 | Comparator pair for phase A {upper, lower} |
| cmp_b_i | input | 2 | Comparator pair for phase B {upper, lower} |
| phase_a_o | output | 1 | Amplifier phase A enable |
| phase_b_o | output | 1 | Amplifier phase B enable |
| done_o | output | 1 | One-period result strobe |
| code_o | output | 12 | Corrected binary code |

## Verification
Some properties can be checked on every cycle, and the assertions cover these. The two phases are never on together. Phase A is always followed by phase B. The done strobe lasts one period and follows a phase-B period. The code only moves under done. A count of phase periods since the last done must reach exactly RES_BITS at done and never go past it, which also catches a start accepted while busy. Other behaviour depends on the data and can only be shown by the bench's scenarios: the digit decoding, including the inconsistent comparator pair, and the redundant-digit arithmetic. Tolerance to offsets is shown by sweeping the input over the full range with a residue model, under several comparator offset settings.

// File: rtl/cadc_pkg.sv
package cadc_pkg;

   // Three-level digit held as a two's complement pair: -1, 0, +1
   typedef logic signed [1:0] digit_t;

   localparam digit_t DIG_POS  = 2'sb01;
   localparam digit_t DIG_ZERO = 2'sb00;
   localparam digit_t DIG_NEG  = 2'sb11;

   // Comparator pair {upper, lower} to digit; an inconsistent pair reads as mid
   function automatic digit_t pair_to_digit(input logic [1:0] pair);
      case (pair)
         2'b11:   return DIG_POS;
         2'b00:   return DIG_NEG;
         default: return DIG_ZERO;
      endcase
   endfunction

endpackage

// File: rtl/cadc_phase_seq.sv
module cadc_phase_seq #(
   parameter int RES_BITS = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic phase_a_o,
   output logic phase_b_o,
   output logic cap_o,
   output logic first_o,
   output logic last_o
);
   localparam int STEP_W = $clog2(RES_BITS);
   localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(RES_BITS - 1);

   logic              busy_q;
   logic [STEP_W-1:0] step_q;
   logic              accept;

   assign accept = start_i && !busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         step_q <= '0;
      end else if (accept) begin
         busy_q <= 1'b1;
         step_q <= '0;
      end else if (busy_q) begin
         if (step_q == LAST_STEP) begin
            busy_q <= 1'b0;
            step_q <= '0;
         end else begin
            step_q <= step_q + 1'b1;
         end
      end
   end

   // Even steps drive phase A, odd steps drive phase B
   assign phase_a_o = busy_q && !step_q[0];
   assign phase_b_o = busy_q &&  step_q[0];
   assign cap_o     = busy_q;
   assign first_o   = busy_q && (step_q == '0);
   assign last_o    = busy_q && (step_q == LAST_STEP);

endmodule

// File: rtl/cadc_digit_dec.sv
module cadc_digit_dec (
   input  logic                 sel_b_i,
   input  logic [1:0]           cmp_a_i,
   input  logic [1:0]           cmp_b_i,
   output cadc_pkg::digit_t     digit_o
);
   logic [1:0] pair;

   assign pair    = sel_b_i ? cmp_b_i : cmp_a_i;
   assign digit_o = cadc_pkg::pair_to_digit(pair);

endmodule

// File: rtl/cadc_corrector.sv
module cadc_corrector #(
   parameter int RES_BITS = 12,
   parameter bit SATURATE = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cap_i,
   input  logic                  first_i,
   input  logic                  last_i,
   input  cadc_pkg::digit_t      digit_i,
   output logic                  done_o,
   output logic [RES_BITS-1:0]   code_o
);
   localparam int ACC_W = RES_BITS + 3;
   localparam logic signed [ACC_W-1:0] BIAS     = ACC_W'(1) << RES_BITS;
   localparam logic signed [ACC_W-1:0] CODE_MAX = (ACC_W'(1) << RES_BITS) - ACC_W'(1);

   logic signed [ACC_W-1:0] acc_q;
   logic signed [ACC_W-1:0] dig_ext;
   logic signed [ACC_W-1:0] sum_next;
   logic signed [ACC_W-1:0] biased;
   logic [RES_BITS-1:0]     code_next;

   assign dig_ext  = {{(ACC_W-2){digit_i[1]}}, digit_i};
   assign sum_next = first_i ? dig_ext : ((acc_q <<< 1) + dig_ext);
   assign biased   = (sum_next + BIAS) >>> 1;

   generate
      if (SATURATE) begin : g_sat
         always_comb begin
            if (biased < 0)
               code_next = '0;
            else if (biased > CODE_MAX)
               code_next = '1;
            else
               code_next = biased[RES_BITS-1:0];
         end
      end else begin : g_wrap
         assign code_next = biased[RES_BITS-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q  <= '0;
         done_o <= 1'b0;
         code_o <= '0;
      end else begin
         done_o <= 1'b0;
         if (cap_i) begin
            acc_q <= sum_next;
            if (last_i) begin
               code_o <= code_next;
               done_o <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/cadc_seq_core.sv
module cadc_seq_core #(
   parameter int RES_BITS = 12,
   parameter bit SATURATE = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic [1:0]          cmp_a_i,
   input  logic [1:0]          cmp_b_i,
   output logic                phase_a_o,
   output logic                phase_b_o,
   output logic                done_o,
   output logic [RES_BITS-1:0] code_o
);
   generate
      if ((RES_BITS % 2) != 0) begin : g_bad_odd
         $error("RES_BITS must be even: two digits per conversion cycle");
      end
      if (RES_BITS < 4 || RES_BITS > 24) begin : g_bad_range
         $error("RES_BITS out of supported range 4..24");
      end
   endgenerate

   logic             cap;
   logic             first;
   logic             last;
   cadc_pkg::digit_t digit;

   cadc_phase_seq #(.RES_BITS(RES_BITS)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .phase_a_o (phase_a_o),
      .phase_b_o (phase_b_o),
      .cap_o     (cap),
      .first_o   (first),
      .last_o    (last)
   );

   cadc_digit_dec u_dec (
      .sel_b_i (phase_b_o),
      .cmp_a_i (cmp_a_i),
      .cmp_b_i (cmp_b_i),
      .digit_o (digit)
   );

   cadc_corrector #(.RES_BITS(RES_BITS), .SATURATE(SATURATE)) u_corr (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap_i   (cap),
      .first_i (first),
      .last_i  (last),
      .digit_i (digit),
      .done_o  (done_o),
      .code_o  (code_o)
   );

endmodule

// File: rtl/cadc_seq_chk.sv
module cadc_seq_chk #(
   parameter int RES_BITS = 12
) (
   input logic                clk,
   input logic                rst_n,
   input logic                phase_a_o,
   input logic                phase_b_o,
   input logic                done_o,
   input logic [RES_BITS-1:0] code_o
);
   localparam int CNT_W = $clog2(RES_BITS + 2);

   logic [CNT_W-1:0] ph_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)
         ph_cnt <= '0;
      else if (done_o)
         ph_cnt <= '0;
      else if (phase_a_o || phase_b_o)
         ph_cnt <= ph_cnt + 1'b1;
   end

   a_r3_phase_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(phase_a_o && phase_b_o));

   a_r2_a_then_b: assert property (@(posedge clk) disable iff (!rst_n)
      phase_a_o |=> phase_b_o);

   a_r2_phase_count: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (ph_cnt == CNT_W'(RES_BITS)));

   a_r8_no_extra_phase: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_a_o || phase_b_o) |-> (ph_cnt < CNT_W'(RES_BITS)));

   a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r6_done_after_b: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(phase_b_o));

   a_r7_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(code_o) |-> done_o);

endmodule

bind cadc_seq_core cadc_seq_chk #(.RES_BITS(RES_BITS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .phase_a_o (phase_a_o),
   .phase_b_o (phase_b_o),
   .done_o    (done_o),
   .code_o    (code_o)
);

// File: tb/cadc_seq_core_tb.sv
module cadc_seq_core_tb;
   localparam int      CLK_PERIOD = 10;
   localparam int      NB         = 12;
   localparam longint  VREF       = 64'd1 << 20;
   localparam longint  OFS_MAX    = VREF / 4 - 1;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          start_i;
   logic [1:0]    cmp_a_i;
   logic [1:0]    cmp_b_i;
   logic          phase_a_o;
   logic          phase_b_o;
   logic          done_o;
   logic [NB-1:0] code_o;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cadc_seq_core #(.RES_BITS(NB)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .cmp_a_i(cmp_a_i), .cmp_b_i(cmp_b_i),
      .phase_a_o(phase_a_o), .phase_b_o(phase_b_o),
      .done_o(done_o), .code_o(code_o)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int dig(input logic [1:0] p);
      if (p == 2'b11) return 1;
      if (p == 2'b00) return -1;
      return 0;
   endfunction

   function automatic int pat_code(input logic [2*NB-1:0] pat);
      longint s = 0;
      longint v;
      for (int k = 0; k < NB; k++)
         s = s * 2 + dig(pat[2*NB-1-2*k -: 2]);
      v = (s + (64'd1 << NB)) >>> 1;
      if (v < 0) v = 0;
      if (v > (64'd1 << NB) - 1) v = (64'd1 << NB) - 1;
      return int'(v);
   endfunction

   // One conversion. use_pat: feed pat directly; else residue model on x.
   // busy_k >= 0: raise start during that phase period (R8).
   task automatic convert(input bit use_pat, input logic [2*NB-1:0] pat,
                          input longint x, input longint oh, input longint ol,
                          input int busy_k, output int code, output bit seq_ok);
      longint r = x;
      logic [1:0] pr;
      seq_ok = 1'b1;
      @(negedge clk);
      start_i = 1'b1;
      for (int k = 0; k < NB; k++) begin
         @(negedge clk);
         start_i = (k == busy_k) ? 1'b1 : 1'b0;
         if (phase_a_o !== ((k % 2) == 0) || phase_b_o !== ((k % 2) == 1) || done_o !== 1'b0)
            seq_ok = 1'b0;
         if (use_pat) begin
            pr = pat[2*NB-1-2*k -: 2];
         end else begin
            pr[1] = (r > VREF / 4 + oh);
            pr[0] = (r > -VREF / 4 + ol);
            r = 2 * r - dig(pr) * VREF;
         end
         if ((k % 2) == 0) begin cmp_a_i = pr; cmp_b_i = ~pr; end
         else              begin cmp_b_i = pr; cmp_a_i = ~pr; end
      end
      @(negedge clk);
      start_i = 1'b0;
      check(done_o === 1'b1, "R6 done after last phase", done_o, 1);
      check(!phase_a_o && !phase_b_o, "R3 idle phases after done", {phase_a_o, phase_b_o}, 0);
      code = int'(code_o);
      @(negedge clk);
      check(done_o === 1'b0, "R6 done one period", done_o, 0);
      check(int'(code_o) == code, "R7 code held after done", code_o, code);
   endtask

   initial begin
      int code, exp, diff;
      bit sok, idle_ok;
      logic [2*NB-1:0] pat;
      logic [15:0] lfsr;
      longint oh_set [5];
      longint ol_set [5];

      rst_n = 1'b0; start_i = 1'b0; cmp_a_i = 2'b00; cmp_b_i = 2'b00;
      repeat (3) @(negedge clk);
      check(!phase_a_o && !phase_b_o && !done_o, "R1 outputs in reset", {phase_a_o, phase_b_o, done_o}, 0);
      check(code_o == 0, "R1 code in reset", code_o, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(!phase_a_o && !phase_b_o && !done_o && code_o == 0, "R1 idle after reset",
            {phase_a_o, phase_b_o, done_o}, 0);

      // R4/R5: fixed digit patterns
      convert(1'b1, {NB{2'b11}}, 0, 0, 0, -1, code, sok);
      check(code == 4095, "R5 all +1", code, 4095);
      check(sok, "R2 phase order", 0, 1);
      convert(1'b1, {NB{2'b00}}, 0, 0, 0, -1, code, sok);
      check(code == 0, "R5 all -1", code, 0);
      convert(1'b1, {NB{2'b01}}, 0, 0, 0, -1, code, sok);
      check(code == 2048, "R5 all mid", code, 2048);
      convert(1'b1, {NB{2'b10}}, 0, 0, 0, -1, code, sok);
      check(code == 2048, "R4 inconsistent pair as mid", code, 2048);
      pat = {2'b11, 2'b00, 2'b11, 2'b00, 2'b11, 2'b00, 2'b11, 2'b00, 2'b11, 2'b00, 2'b11, 2'b00};
      convert(1'b1, pat, 0, 0, 0, -1, code, sok);
      check(code == pat_code(pat), "R5 alternating digits", code, pat_code(pat));

      // R4/R5: pseudo-random digit patterns
      lfsr = 16'hACE1;
      for (int t = 0; t < 64; t++) begin
         for (int k = 0; k < NB; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            pat[2*NB-1-2*k -: 2] = lfsr[1:0];
         end
         convert(1'b1, pat, 0, 0, 0, -1, code, sok);
         exp = pat_code(pat);
         check(code == exp, "R4 R5 random pattern", code, exp);
         check(sok, "R2 R3 phase sequence", 0, 1);
      end

      // R8: start during conversion ignored
      pat = {2'b11, 2'b01, 2'b00, 2'b11, 2'b10, 2'b01, 2'b11, 2'b00, 2'b00, 2'b01, 2'b11, 2'b11};
      convert(1'b1, pat, 0, 0, 0, 5, code, sok);
      check(code == pat_code(pat), "R8 busy start, result", code, pat_code(pat));
      check(sok, "R8 busy start, schedule", 0, 1);
      idle_ok = 1'b1;
      for (int i = 0; i < NB + 4; i++) begin
         @(negedge clk);
         if (phase_a_o || phase_b_o || done_o || code_o != 12'(code)) idle_ok = 1'b0;
      end
      check(idle_ok, "R8 no restart after busy start", 0, 1);

      // R9: full-range sweep under comparator offsets
      oh_set = '{0, OFS_MAX, -OFS_MAX, OFS_MAX, -OFS_MAX};
      ol_set = '{0, OFS_MAX, -OFS_MAX, -OFS_MAX, OFS_MAX};
      for (int o = 0; o < 5; o++) begin
         for (int i = 0; i <= 256; i++) begin
            longint x = -VREF + longint'(i) * (2 * VREF / 256);
            longint idl = ((x + VREF) * 2048) / VREF;
            if (idl > 4095) idl = 4095;
            convert(1'b0, '0, x, oh_set[o], ol_set[o], -1, code, sok);
            diff = code - int'(idl);
            check(diff >= -1 && diff <= 1, "R9 code vs ideal", code, idl);
            check(sok, "R2 R3 phase sequence in sweep", 0, 1);
         end
      end

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

endmodule